// File: doc/BRIEF.md
# Branch Trace Packet Generator

This block sits beside a processor core and turns the stream of retirement events into a compact control-flow trace. Each accepted event says what kind of control transfer retired. Conditional branches add one outcome bit each to an internal pending vector. Indirect branches, returns, asynchronous interrupts and transactional state changes emit address and mode packets in a fixed order. Straight-line code and direct jumps are presented as a plain event and produce nothing.

Packets leave through a valid/ready stream. Each packet carries a 3-bit type, a 64-bit payload and a count of valid outcome bits. A four-entry queue absorbs the bursts of up to four packets that one event can cause. When the queue lacks room for the packets of the event now offered, the event input is stalled. No packet is ever dropped.

Top module: `branch_trace_gen`

## Requirements
- R1: An accepted conditional event (kind 1) appends one bit to the pending vector: 1 for taken, 0 for not taken. The oldest outcome sits in payload bit 0 and later ones in rising bit positions.
- R2: An accepted plain event (kind 0) emits no packet and leaves the pending outcome bits unchanged.
- R3: When a conditional event brings the pending count to LONG_BITS (64), a long packet (type 1, count 64) is queued in that same acceptance and the pending vector is emptied.
- R4: Before any target, flow-update or mode packet, a non-empty pending vector is flushed. It becomes type 0 if it holds at most SHORT_BITS (8) bits and type 1 otherwise, with the count equal to the number of pending bits and all payload bits above the count zero.
- R5: An indirect branch (kind 2) or a return (kind 3) emits one target packet (type 2) whose payload is the destination input.
- R6: An interrupt (kind 4) emits a flow-update packet (type 3) carrying the source input, directly followed by a target packet carrying the destination input.
- R7: A transaction begin (kind 5) or commit (kind 6) emits a mode packet (type 4) followed by a flow-update packet carrying the source input. The mode payload is 1 after a begin and 0 after a commit.
- R8: A transaction abort (kind 7) emits a mode packet with payload 2, a flow-update packet carrying the source, and a target packet carrying the destination, in that order.
- R9: Target, flow-update and mode packets carry a count of 0.
- R10: While pkt_valid is high and pkt_ready is low, the output packet stays unchanged. evt_ready is low whenever the queue has fewer free entries than the offered event would produce. Every produced packet is delivered once, in order.
- R11: During and right after reset, pkt_valid is low, evt_ready is high and no outcome bits are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A retirement event is offered |
| evt_ready | output | 1 | The offered event is accepted this cycle |
| evt_kind | input | 3 | Event kind 0..7 (plain, conditional, indirect, return, interrupt, begin, commit, abort) |
| evt_taken | input | 1 | Outcome of a conditional event |
| evt_src | input | 64 | Source code location (interrupt, transactional events) |
| evt_dst | input | 64 | Destination location (indirect, return, interrupt, abort handler) |
| pkt_valid | output | 1 | A packet is presented |
| pkt_ready | input | 1 | The consumer takes the presented packet |
| pkt_type | output | 3 | 0 short bits, 1 long bits, 2 target, 3 flow-update, 4 mode |
| pkt_payload | output | 64 | Outcome bits, address or mode value |
| pkt_nbits | output | 7 | Number of valid outcome bits (0 for non-bit packets) |

## Verification
The bench builds the block with its defaults: an 8-bit short form, a 64-bit long form and a four-entry queue. A queue exactly as deep as the largest burst means an abort arriving with pending bits fits only into an empty queue, so holding the consumer off for a few cycles reliably drives evt_ready low. The 64-bit long form keeps the automatic emission at the 64th outcome, and flushes of 8, 9 and 63 bits, within a short directed run. A long mixed run with a randomly stalling consumer then covers back-to-back bursts against the scoreboard.

// File: rtl/btpg_pkg.sv
package btpg_pkg;
    localparam int PAYLOAD_W = 64;
    localparam int NBITS_W   = 7;
    localparam int BURST_MAX = 4;   // flush + mode + flow-update + target

    typedef enum logic [2:0] {
        EV_PLAIN     = 3'd0,
        EV_COND      = 3'd1,
        EV_INDIRECT  = 3'd2,
        EV_RETURN    = 3'd3,
        EV_INTR      = 3'd4,
        EV_TX_BEGIN  = 3'd5,
        EV_TX_COMMIT = 3'd6,
        EV_TX_ABORT  = 3'd7
    } ev_kind_e;

    typedef enum logic [2:0] {
        PK_SHORT  = 3'd0,
        PK_LONG   = 3'd1,
        PK_TARGET = 3'd2,
        PK_FLOW   = 3'd3,
        PK_MODE   = 3'd4
    } pk_kind_e;

    localparam logic [PAYLOAD_W-1:0] MODE_IN_TX   = 64'd1;
    localparam logic [PAYLOAD_W-1:0] MODE_NO_TX   = 64'd0;
    localparam logic [PAYLOAD_W-1:0] MODE_ABORTED = 64'd2;

    typedef struct packed {
        logic [2:0]           kind;
        logic [PAYLOAD_W-1:0] payload;
        logic [NBITS_W-1:0]   nbits;
    } pkt_t;
endpackage

// File: rtl/btpg_fifo.sv
module btpg_fifo
    import btpg_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int WR_MAX = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(WR_MAX+1)-1:0]      push_n,
    input  pkt_t                             push_ent [WR_MAX],
    input  logic                             pop,
    output pkt_t                             head,
    output logic                             not_empty,
    output logic [$clog2(DEPTH+1)-1:0]       free_cnt
);
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int WCW = $clog2(WR_MAX + 1);

    typedef struct packed {
        pkt_t [DEPTH-1:0] mem;
        logic [PW-1:0]    rd;
        logic [PW-1:0]    wr;
        logic [CW-1:0]    cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     pop_ok;

    always_comb begin
        st_d   = st_q;
        pop_ok = pop && (st_q.cnt != '0);
        for (int i = 0; i < WR_MAX; i++) begin
            if (WCW'(i) < push_n) begin
                st_d.mem[st_q.wr + PW'(i)] = push_ent[i];
            end
        end
        st_d.wr  = st_q.wr + PW'(push_n);
        if (pop_ok) begin
            st_d.rd = st_q.rd + PW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(push_n) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head      = st_q.mem[st_q.rd];
    assign not_empty = (st_q.cnt != '0);
    assign free_cnt  = CW'(DEPTH) - st_q.cnt;
endmodule

// File: rtl/btpg_burst.sv
module btpg_burst
    import btpg_pkg::*;
#(
    parameter int SHORT_BITS = 8,
    parameter int LONG_BITS  = 64
) (
    input  logic [2:0]                       kind,
    input  logic                             taken,
    input  logic [PAYLOAD_W-1:0]             src,
    input  logic [PAYLOAD_W-1:0]             dst,
    input  logic [PAYLOAD_W-1:0]             pend_bits,
    input  logic [NBITS_W-1:0]               pend_cnt,
    output pkt_t                             ent [BURST_MAX],
    output logic [$clog2(BURST_MAX+1)-1:0]   ent_n,
    output logic [PAYLOAD_W-1:0]             pend_bits_nx,
    output logic [NBITS_W-1:0]               pend_cnt_nx
);
    localparam int IDX_W = $clog2(LONG_BITS);
    localparam int BCW   = $clog2(BURST_MAX + 1);
    localparam logic [NBITS_W-1:0] SHORT_N = NBITS_W'(SHORT_BITS);
    localparam logic [NBITS_W-1:0] LONG_N  = NBITS_W'(LONG_BITS);
    localparam logic [NBITS_W-1:0] LAST_N  = NBITS_W'(LONG_BITS - 1);

    pkt_t                 flush_p;
    pkt_t                 tail [BURST_MAX-1];
    logic [BCW-1:0]       tail_n;
    logic                 emits_addr;
    logic [PAYLOAD_W-1:0] merged;

    // packet for the pending outcome vector, short or long by its fill
    always_comb begin
        flush_p.kind    = (pend_cnt <= SHORT_N) ? PK_SHORT : PK_LONG;
        flush_p.payload = pend_bits;
        flush_p.nbits   = pend_cnt;
        merged          = pend_bits;
        merged[pend_cnt[IDX_W-1:0]] = taken;
    end

    // packets that follow the flush, in program order
    always_comb begin
        for (int i = 0; i < BURST_MAX - 1; i++) tail[i] = '0;
        tail_n     = '0;
        emits_addr = 1'b1;
        case (kind)
            EV_INDIRECT, EV_RETURN: begin
                tail[0] = '{kind: PK_TARGET, payload: dst, nbits: '0};
                tail_n  = BCW'(1);
            end
            EV_INTR: begin
                tail[0] = '{kind: PK_FLOW,   payload: src, nbits: '0};
                tail[1] = '{kind: PK_TARGET, payload: dst, nbits: '0};
                tail_n  = BCW'(2);
            end
            EV_TX_BEGIN, EV_TX_COMMIT: begin
                tail[0] = '{kind: PK_MODE,
                            payload: (kind == EV_TX_BEGIN) ? MODE_IN_TX : MODE_NO_TX,
                            nbits: '0};
                tail[1] = '{kind: PK_FLOW, payload: src, nbits: '0};
                tail_n  = BCW'(2);
            end
            EV_TX_ABORT: begin
                tail[0] = '{kind: PK_MODE,   payload: MODE_ABORTED, nbits: '0};
                tail[1] = '{kind: PK_FLOW,   payload: src, nbits: '0};
                tail[2] = '{kind: PK_TARGET, payload: dst, nbits: '0};
                tail_n  = BCW'(3);
            end
            default: emits_addr = 1'b0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < BURST_MAX; i++) ent[i] = '0;
        ent_n        = '0;
        pend_bits_nx = pend_bits;
        pend_cnt_nx  = pend_cnt;
        if (kind == EV_COND) begin
            if (pend_cnt == LAST_N) begin
                ent[0]       = '{kind: PK_LONG, payload: merged, nbits: LONG_N};
                ent_n        = BCW'(1);
                pend_bits_nx = '0;
                pend_cnt_nx  = '0;
            end else begin
                pend_bits_nx = merged;
                pend_cnt_nx  = pend_cnt + NBITS_W'(1);
            end
        end else if (emits_addr) begin
            pend_bits_nx = '0;
            pend_cnt_nx  = '0;
            if (pend_cnt != '0) begin
                ent[0] = flush_p;
                for (int i = 0; i < BURST_MAX - 1; i++) ent[i+1] = tail[i];
                ent_n  = tail_n + BCW'(1);
            end else begin
                for (int i = 0; i < BURST_MAX - 1; i++) ent[i] = tail[i];
                ent_n  = tail_n;
            end
        end
    end
endmodule

// File: rtl/branch_trace_gen.sv
module branch_trace_gen
    import btpg_pkg::*;
#(
    parameter int SHORT_BITS = 8,
    parameter int LONG_BITS  = 64,
    parameter int DEPTH      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_valid,
    output logic        evt_ready,
    input  logic [2:0]  evt_kind,
    input  logic        evt_taken,
    input  logic [63:0] evt_src,
    input  logic [63:0] evt_dst,
    output logic        pkt_valid,
    input  logic        pkt_ready,
    output logic [2:0]  pkt_type,
    output logic [63:0] pkt_payload,
    output logic [6:0]  pkt_nbits
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int BCW = $clog2(BURST_MAX + 1);

    typedef struct packed {
        logic [PAYLOAD_W-1:0] bits;
        logic [NBITS_W-1:0]   cnt;
    } acc_t;

    acc_t                 acc_d, acc_q;
    pkt_t                 ent [BURST_MAX];
    logic [BCW-1:0]       ent_n;
    logic [BCW-1:0]       push_n;
    logic [PAYLOAD_W-1:0] bits_nx;
    logic [NBITS_W-1:0]   cnt_nx;
    logic [CW-1:0]        free_cnt;
    logic                 accept;
    pkt_t                 head;
    logic                 not_empty;

    btpg_burst #(
        .SHORT_BITS (SHORT_BITS),
        .LONG_BITS  (LONG_BITS)
    ) u_burst (
        .kind         (evt_kind),
        .taken        (evt_taken),
        .src          (evt_src),
        .dst          (evt_dst),
        .pend_bits    (acc_q.bits),
        .pend_cnt     (acc_q.cnt),
        .ent          (ent),
        .ent_n        (ent_n),
        .pend_bits_nx (bits_nx),
        .pend_cnt_nx  (cnt_nx)
    );

    btpg_fifo #(
        .DEPTH  (DEPTH),
        .WR_MAX (BURST_MAX)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (push_n),
        .push_ent  (ent),
        .pop       (pkt_ready),
        .head      (head),
        .not_empty (not_empty),
        .free_cnt  (free_cnt)
    );

    always_comb begin
        evt_ready = (free_cnt >= CW'(ent_n));
        accept    = evt_valid && evt_ready;
        push_n    = accept ? ent_n : '0;
        acc_d     = acc_q;
        if (accept) begin
            acc_d.bits = bits_nx;
            acc_d.cnt  = cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign pkt_valid   = not_empty;
    assign pkt_type    = head.kind;
    assign pkt_payload = head.payload;
    assign pkt_nbits   = head.nbits;
endmodule

// File: rtl/btpg_chk.sv
module btpg_chk #(
    parameter int SHORT_BITS = 8,
    parameter int LONG_BITS  = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_valid,
    input logic        evt_ready,
    input logic [2:0]  evt_kind,
    input logic        pkt_valid,
    input logic        pkt_ready,
    input logic [2:0]  pkt_type,
    input logic [63:0] pkt_payload,
    input logic [6:0]  pkt_nbits
);
    // R10
    pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_type)
            && $stable(pkt_payload) && $stable(pkt_nbits));

    // R4
    short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_type == 3'd0 |-> pkt_nbits >= 7'd1
            && pkt_nbits <= 7'(SHORT_BITS));

    // R4
    long_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_type == 3'd1 |-> pkt_nbits > 7'(SHORT_BITS)
            && pkt_nbits <= 7'(LONG_BITS));

    // R4
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_type <= 3'd1 |-> (pkt_payload >> pkt_nbits) == 64'd0);

    // R9
    addr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_type >= 3'd2 |-> pkt_nbits == 7'd0 && pkt_type <= 3'd4);

    // R2
    plain_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_ready && evt_kind == 3'd0 && !pkt_valid |=> !pkt_valid);
endmodule

bind branch_trace_gen btpg_chk #(
    .SHORT_BITS (SHORT_BITS),
    .LONG_BITS  (LONG_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_ready   (evt_ready),
    .evt_kind    (evt_kind),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .pkt_type    (pkt_type),
    .pkt_payload (pkt_payload),
    .pkt_nbits   (pkt_nbits)
);

// File: tb/sim_branch_trace_gen.sv
`timescale 1ns/1ps
module sim_branch_trace_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [2:0]  evt_kind = 3'd0;
    logic        evt_taken = 1'b0;
    logic [63:0] evt_src = '0;
    logic [63:0] evt_dst = '0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b1;
    logic [2:0]  pkt_type;
    logic [63:0] pkt_payload;
    logic [6:0]  pkt_nbits;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int ready_mode = 0;   // 0 always, 1 random, 2 held off
    logic stalled_seen = 1'b0;
    logic [73:0] exp_q [$];
    string       tag_q [$];
    logic [63:0] m_bits = '0;
    int          m_cnt = 0;
    logic        hold_prev = 1'b0;
    logic [73:0] hold_snap = '0;

    always #5 clk = ~clk;

    branch_trace_gen u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_kind(evt_kind), .evt_taken(evt_taken), .evt_src(evt_src), .evt_dst(evt_dst),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_type(pkt_type),
        .pkt_payload(pkt_payload), .pkt_nbits(pkt_nbits)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [73:0] act, input logic [73:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_push(input logic [2:0] t, input logic [63:0] p,
                            input int n, input string tag);
        exp_q.push_back({t, p, 7'(n)});
        tag_q.push_back(tag);
    endtask

    // R4: pending bits go out before any address or mode packet
    task automatic model_flush();
        if (m_cnt > 0) exp_push((m_cnt <= 8) ? 3'd0 : 3'd1, m_bits, m_cnt, "R1/R4");
        m_bits = '0;
        m_cnt  = 0;
    endtask

    task automatic model(input logic [2:0] k, input logic t,
                         input logic [63:0] s, input logic [63:0] d);
        case (k)
            3'd0: ;                                   // R2: nothing
            3'd1: begin                               // R1, R3
                m_bits[m_cnt] = t;
                m_cnt++;
                if (m_cnt == 64) begin
                    exp_push(3'd1, m_bits, 64, "R3");
                    m_bits = '0;
                    m_cnt  = 0;
                end
            end
            3'd2, 3'd3: begin                         // R5
                model_flush();
                exp_push(3'd2, d, 0, "R5");
            end
            3'd4: begin                               // R6
                model_flush();
                exp_push(3'd3, s, 0, "R6");
                exp_push(3'd2, d, 0, "R6");
            end
            3'd5, 3'd6: begin                         // R7
                model_flush();
                exp_push(3'd4, (k == 3'd5) ? 64'd1 : 64'd0, 0, "R7");
                exp_push(3'd3, s, 0, "R7");
            end
            default: begin                            // R8
                model_flush();
                exp_push(3'd4, 64'd2, 0, "R8");
                exp_push(3'd3, s, 0, "R8");
                exp_push(3'd2, d, 0, "R8");
            end
        endcase
    endtask

    // called at posedge+2; returns at posedge+2 after acceptance
    task automatic send(input logic [2:0] k, input logic t,
                        input logic [63:0] s, input logic [63:0] d);
        evt_valid = 1'b1;
        evt_kind  = k;
        evt_taken = t;
        evt_src   = s;
        evt_dst   = d;
        forever begin
            @(negedge clk);
            if (evt_ready) break;
            stalled_seen = 1'b1;
        end
        model(k, t, s, d);
        @(posedge clk);
        #2;
        evt_valid = 1'b0;
    endtask

    task automatic conds(input int n, input logic [63:0] pat);
        for (int i = 0; i < n; i++) send(3'd1, pat[i % 64], '0, '0);
    endtask

    task automatic drain();
        for (int i = 0; i < 2000; i++) begin
            if (exp_q.size() == 0) break;
            @(posedge clk);
        end
        @(posedge clk);
        #2;
    endtask

    // consumer ready pattern
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0:       pkt_ready = 1'b1;
            1:       pkt_ready = lfsr[0] | lfsr[3];
            default: pkt_ready = 1'b0;
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_valid) begin
                if (hold_prev)  // R10: held packet unchanged
                    check({pkt_type, pkt_payload, pkt_nbits} == hold_snap, "R10 hold",
                          {pkt_type, pkt_payload, pkt_nbits}, hold_snap);
                if (pkt_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10 unexpected packet",
                              {pkt_type, pkt_payload, pkt_nbits}, '0);
                    end else begin
                        check({pkt_type, pkt_payload, pkt_nbits} == exp_q[0], tag_q[0],
                              {pkt_type, pkt_payload, pkt_nbits}, exp_q[0]);
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                    end
                end
                hold_prev = !pkt_ready;
                hold_snap = {pkt_type, pkt_payload, pkt_nbits};
            end else begin
                hold_prev = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(pkt_valid == 1'b0, "R11 pkt_valid", {73'd0, pkt_valid}, '0);
        check(evt_ready == 1'b1, "R11 evt_ready", {73'd0, evt_ready}, 74'd1);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(posedge clk);
        #2;

        // R1, R2, R5: 1,0,(plain),1 then indirect -> short 3'b101
        send(3'd1, 1'b1, '0, '0);
        send(3'd1, 1'b0, '0, '0);
        send(3'd0, 1'b1, 64'h1111, 64'h2222);
        send(3'd1, 1'b1, '0, '0);
        send(3'd2, 1'b0, 64'h0, 64'hDEAD_BEEF_0000_1000);
        drain();
        // R3: 64 outcomes emit long packet with no later flush
        conds(64, 64'hF0E1_D2C3_B4A5_9687);
        send(3'd3, 1'b0, 64'h0, 64'h0000_7FFF_0000_0040);
        drain();
        // R4 boundaries: 8 -> short, 9 -> long, 63 -> long
        conds(8, 64'h0000_0000_0000_00A5);
        send(3'd3, 1'b0, 64'h0, 64'h10);
        conds(9, 64'h0000_0000_0000_01FF);
        send(3'd2, 1'b0, 64'h0, 64'h20);
        conds(63, 64'h5555_AAAA_3333_CCCC);
        send(3'd2, 1'b0, 64'h0, 64'h30);
        drain();
        // R6: interrupt after 12 outcomes
        conds(12, 64'h0000_0000_0000_0ABC);
        send(3'd4, 1'b0, 64'h0000_0000_4000_1234, 64'hFFFF_8000_0000_0E00);
        // R7: begin / commit with nothing pending
        send(3'd5, 1'b0, 64'h0000_0000_0040_0100, 64'h0);
        send(3'd6, 1'b0, 64'h0000_0000_0040_0180, 64'h0);
        drain();

        // R8, R10: abort with pending bits while the consumer is held off
        ready_mode   = 2;
        @(posedge clk);
        #2;
        stalled_seen = 1'b0;
        conds(5, 64'h0000_0000_0000_0016);
        send(3'd7, 1'b0, 64'h0000_0000_0050_0000, 64'h0000_0000_0060_0000);
        fork
            begin
                repeat (20) @(posedge clk);
                #1;
                ready_mode = 0;
            end
            send(3'd7, 1'b0, 64'h0000_0000_0050_0040, 64'h0000_0000_0060_0040);
        join
        check(stalled_seen == 1'b1, "R10 evt_ready low on full queue",
              {73'd0, stalled_seen}, 74'd1);
        drain();

        // mixed run with a randomly stalling consumer
        ready_mode = 1;
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [2:0] k;
            r = $urandom_range(0, 15);
            k = (r < 8) ? 3'd1 : 3'(r - 8);
            send(k, 1'($urandom_range(0, 1)), {$urandom, $urandom}, {$urandom, $urandom});
        end
        send(3'd2, 1'b0, 64'h0, 64'h99);
        ready_mode = 0;
        drain();
        // R10: nothing lost or left over
        check(exp_q.size() == 0 && !pkt_valid, "R10 all delivered",
              {42'd0, 32'(exp_q.size())}, '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule